// File: doc/BRIEF.md
# Video Capture Line Address Generator

This block computes the memory address where each captured video line begins. It keeps three address streams: luma (Y), which also serves as the single stream in linear mode, and the two chroma planes U and V. Software programs an odd-field and an even-field base address for each plane, two pitches and a control word through a small synchronous register port. Frame and field strobes reload the running pointers from the base set that the field polarity selects. Each line strobe hands the current addresses to the write engine and moves every active pointer forward by its plane's pitch.

In linear mode only the Y stream runs. In planar mode the Y pitch drives the Y plane and a separate chroma pitch drives both U and V. For interlaced capture, a control bit chooses whether the pointers reload at every field or only at every frame. A second bit points the even-field chroma planes at the odd-field chroma bases. An overflow controller either drops the rest of the damaged line and resumes on its own, or halts with an interrupt until software pulses a FIFO reset.

Top module: `vcap_addr_gen`

## Requirements
- R1: Register port offsets, with reg_rdata holding the word at reg_addr one cycle later:
  - 0/1: Y odd/even base.
  - 2/3: U odd/even base.
  - 4/5: V odd/even base.
  - 6: pitch word. Bits 31:16 are the chroma pitch and bits 15:0 are the Y pitch. The low 5 bits of each half always read 0.
  - 7: control word. Bit 0 = planar, bit 1 = interlaced, bit 2 = reload per field, bit 3 = even chroma uses odd base, bit 5 = overflow recovery enable. Every other bit reads 0.
  - After reset, control reads 0x00000020 and every other register reads 0.
- R2: A line_start that is accepted raises line_valid in the next cycle. In that cycle each active plane's line address shows the pointer value it held before the strobe, and that pointer has advanced by the plane's pitch.
- R3: The Y plane advances by the Y pitch. The U and V planes both advance by the chroma pitch.
- R4: When the planar bit is 0, u_line_addr and v_line_addr read 0 and do not advance. Only the Y stream is generated.
- R5: frame_start reloads every active pointer. When the interlaced bit is 1, field_odd=1 selects the odd base and field_odd=0 selects the even base. When the interlaced bit is 0, the odd base is always used.
- R6: In interlaced mode, field_start reloads the pointers (with the R5 base selection) only when the per-field bit is 1. When that bit is 0, field_start has no effect.
- R7: In progressive mode, field_start never reloads, whatever the per-field bit says.
- R8: With the even-chroma bit set, an even-field reload takes the U and V odd bases. Y still takes its even base.
- R9: When a reload and a line_start arrive in the same cycle, the line gets the reloaded base and the pointer becomes base plus pitch.
- R10: When the recovery bit is 0, fifo_overflow sets ovf_irq and line_drop. Until a fifo_reset pulse clears them, line_start, frame_start and field_start are ignored. The strobes in the fifo_reset cycle itself are still ignored.
- R11: When the recovery bit is 1, fifo_overflow sets line_drop but not ovf_irq. The next line_start is processed normally and clears line_drop.
- R12: Addresses wrap modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| frame_start | input | 1 | Start-of-frame strobe |
| field_start | input | 1 | Start-of-field strobe |
| field_odd | input | 1 | Field polarity, 1 = odd |
| line_start | input | 1 | Start-of-line strobe |
| fifo_overflow | input | 1 | Capture FIFO overflow pulse |
| fifo_reset | input | 1 | Software FIFO reset pulse |
| line_valid | output | 1 | New line addresses present |
| y_line_addr | output | ADDR_W | Y / linear line start address |
| u_line_addr | output | ADDR_W | U line start address |
| v_line_addr | output | ADDR_W | V line start address |
| line_drop | output | 1 | Current line data is to be discarded |
| ovf_irq | output | 1 | Overflow interrupt, halted state |

## Verification
The bench builds the block with ADDR_W = 16. This keeps base and pitch values small enough that wraparound past 0xFFFF (R12) is reached in two lines. It also lets every address be predicted with plain 16-bit arithmetic. With those widths, the bench sweeps all sixteen combinations of the planar, interlaced, per-field and even-chroma bits. Each combination runs through a fixed pattern of frame, field and line strobes with both polarities, which covers every reload-selection path, including reload and line start in the same cycle. The overflow paths are run separately with recovery on and off.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

    localparam int NUM_PLANES = 3;
    localparam int NUM_BASES  = 2 * NUM_PLANES;
    localparam int PITCH_W    = 16;
    localparam int ALIGN_BITS = 5;

    localparam logic [2:0] OFF_PITCH = 3'd6;
    localparam logic [2:0] OFF_CTRL  = 3'd7;

    localparam int CB_PLANAR    = 0;
    localparam int CB_INTERLACE = 1;
    localparam int CB_PER_FIELD = 2;
    localparam int CB_UV_ODD    = 3;
    localparam int CB_RECOVER   = 5;

    typedef struct packed {
        logic recover_en;
        logic uv_even_from_odd;
        logic per_field;
        logic interlaced;
        logic planar;
    } ctrl_t;

    typedef enum logic [1:0] {
        OVF_RUN  = 2'd0,
        OVF_DROP = 2'd1,
        OVF_HALT = 2'd2
    } ovf_state_e;

endpackage

// File: rtl/vcap_regs.sv
module vcap_regs
    import vcap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr,
    input  logic [2:0]                             addr,
    input  logic [31:0]                            wdata,
    output logic [31:0]                            rdata,
    output logic [NUM_BASES-1:0][ADDR_W-1:0]       bases,
    output logic [PITCH_W-1:0]                     pitch_y,
    output logic [PITCH_W-1:0]                     pitch_uv,
    output ctrl_t                                  ctrl
);

    localparam logic [PITCH_W-1:0] PITCH_MASK = ~PITCH_W'((1 << ALIGN_BITS) - 1);

    typedef struct packed {
        logic [NUM_BASES-1:0][ADDR_W-1:0] base;
        logic [PITCH_W-1:0]               py;
        logic [PITCH_W-1:0]               puv;
        ctrl_t                            ctrl;
        logic [31:0]                      rdata;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // registered read of the currently addressed word
        s_d.rdata = '0;
        if (addr == OFF_PITCH) begin
            s_d.rdata = {s_q.puv, s_q.py};
        end else if (addr == OFF_CTRL) begin
            s_d.rdata[CB_PLANAR]    = s_q.ctrl.planar;
            s_d.rdata[CB_INTERLACE] = s_q.ctrl.interlaced;
            s_d.rdata[CB_PER_FIELD] = s_q.ctrl.per_field;
            s_d.rdata[CB_UV_ODD]    = s_q.ctrl.uv_even_from_odd;
            s_d.rdata[CB_RECOVER]   = s_q.ctrl.recover_en;
        end else begin
            for (int i = 0; i < NUM_BASES; i++) begin
                if (addr == 3'(i)) s_d.rdata = 32'(s_q.base[i]);
            end
        end
        // writes
        if (wr) begin
            if (addr == OFF_PITCH) begin
                s_d.py  = wdata[PITCH_W-1:0] & PITCH_MASK;
                s_d.puv = wdata[31:32-PITCH_W] & PITCH_MASK;
            end else if (addr == OFF_CTRL) begin
                s_d.ctrl.planar           = wdata[CB_PLANAR];
                s_d.ctrl.interlaced       = wdata[CB_INTERLACE];
                s_d.ctrl.per_field        = wdata[CB_PER_FIELD];
                s_d.ctrl.uv_even_from_odd = wdata[CB_UV_ODD];
                s_d.ctrl.recover_en       = wdata[CB_RECOVER];
            end else begin
                for (int i = 0; i < NUM_BASES; i++) begin
                    if (addr == 3'(i)) s_d.base[i] = wdata[ADDR_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q                 <= '0;
            s_q.ctrl.recover_en <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata    = s_q.rdata;
    assign bases    = s_q.base;
    assign pitch_y  = s_q.py;
    assign pitch_uv = s_q.puv;
    assign ctrl     = s_q.ctrl;

    // R1: control word only changes on a register write
    assert_ctrl_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(s_q.ctrl));

endmodule

// File: rtl/vcap_plane_ptr.sv
module vcap_plane_ptr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              reload,
    input  logic [ADDR_W-1:0] base,
    input  logic              advance,
    input  logic [ADDR_W-1:0] pitch,
    output logic [ADDR_W-1:0] line_addr
);

    typedef struct packed {
        logic [ADDR_W-1:0] run;
        logic [ADDR_W-1:0] line;
    } ptr_t;

    ptr_t s_d, s_q;
    logic [ADDR_W-1:0] start_w;

    always_comb begin
        s_d     = s_q;
        start_w = reload ? base : s_q.run;
        if (!enable) begin
            s_d = '0;
        end else begin
            s_d.run = start_w;
            if (advance) begin
                s_d.line = start_w;
                s_d.run  = start_w + pitch;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign line_addr = s_q.line;

    // R2: after a line, the pointer sits one pitch beyond the published line
    assert_step_by_pitch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && advance) |=> (s_q.run == s_q.line + $past(pitch)));

    // R9: reload and line in one cycle publish the base itself
    assert_reload_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && reload && advance) |=> (s_q.line == $past(base)));

    // R4: an inactive plane stays cleared
    assert_idle_plane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (s_q.line == '0 && s_q.run == '0));

endmodule

// File: rtl/vcap_ovf_ctl.sv
module vcap_ovf_ctl
    import vcap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic overflow,
    input  logic fifo_reset,
    input  logic line_start,
    input  logic recover_en,
    output logic halted,
    output logic dropping
);

    typedef struct packed {
        ovf_state_e state;
    } ovf_t;

    ovf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            OVF_RUN:  if (overflow) s_d.state = recover_en ? OVF_DROP : OVF_HALT;
            OVF_DROP: if (line_start && !overflow) s_d.state = OVF_RUN;
            OVF_HALT: if (fifo_reset) s_d.state = OVF_RUN;
            default:  s_d.state = OVF_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q.state <= OVF_RUN;
        else        s_q <= s_d;
    end

    assign halted   = (s_q.state == OVF_HALT);
    assign dropping = (s_q.state != OVF_RUN);

    // R10: the halted state holds until software resets the FIFO
    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !fifo_reset) |=> halted);

    // R11: a clean line start ends a drop
    assert_drop_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == OVF_DROP && line_start && !overflow) |=> !dropping);

    // R11: recovery mode never raises the interrupt from the running state
    assert_recover_no_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == OVF_RUN && recover_en) |=> !halted);

endmodule

// File: rtl/vcap_addr_gen.sv
module vcap_addr_gen
    import vcap_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              frame_start,
    input  logic              field_start,
    input  logic              field_odd,
    input  logic              line_start,
    input  logic              fifo_overflow,
    input  logic              fifo_reset,
    output logic              line_valid,
    output logic [ADDR_W-1:0] y_line_addr,
    output logic [ADDR_W-1:0] u_line_addr,
    output logic [ADDR_W-1:0] v_line_addr,
    output logic              line_drop,
    output logic              ovf_irq
);

    logic [NUM_BASES-1:0][ADDR_W-1:0]  bases;
    logic [PITCH_W-1:0]                pitch_y, pitch_uv;
    ctrl_t                             ctrl;
    logic                              halted, dropping;
    logic                              accept_line, reload, even_sel;
    logic [NUM_PLANES-1:0][ADDR_W-1:0] plane_addr;

    typedef struct packed {
        logic valid;
    } top_t;

    top_t s_d, s_q;

    vcap_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .bases    (bases),
        .pitch_y  (pitch_y),
        .pitch_uv (pitch_uv),
        .ctrl     (ctrl)
    );

    vcap_ovf_ctl u_ovf (
        .clk        (clk),
        .rst_n      (rst_n),
        .overflow   (fifo_overflow),
        .fifo_reset (fifo_reset),
        .line_start (line_start),
        .recover_en (ctrl.recover_en),
        .halted     (halted),
        .dropping   (dropping)
    );

    always_comb begin
        accept_line = line_start && !halted;
        reload      = !halted && (frame_start ||
                      (field_start && ctrl.interlaced && ctrl.per_field));
        even_sel    = ctrl.interlaced && !field_odd;
        s_d.valid   = accept_line;
    end

    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
        logic              take_even;
        logic [ADDR_W-1:0] base_pick;
        logic [ADDR_W-1:0] step;
        logic              active;

        if (p == 0) begin : g_luma
            assign take_even = even_sel;
            assign step      = ADDR_W'(pitch_y);
            assign active    = 1'b1;
        end else begin : g_chroma
            assign take_even = even_sel && !ctrl.uv_even_from_odd;
            assign step      = ADDR_W'(pitch_uv);
            assign active    = ctrl.planar;
        end

        assign base_pick = take_even ? bases[2*p+1] : bases[2*p];

        vcap_plane_ptr #(.ADDR_W(ADDR_W)) u_ptr (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (active),
            .reload    (reload),
            .base      (base_pick),
            .advance   (accept_line),
            .pitch     (step),
            .line_addr (plane_addr[p])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign line_valid  = s_q.valid;
    assign y_line_addr = plane_addr[0];
    assign u_line_addr = plane_addr[1];
    assign v_line_addr = plane_addr[2];
    assign line_drop   = dropping;
    assign ovf_irq     = halted;

    // R10: no line is issued while halted
    assert_halt_blocks_lines_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |=> !line_valid);

    // R4: chroma outputs stay zero in linear mode
    assert_linear_uv_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ctrl.planar) |-> (u_line_addr == '0 && v_line_addr == '0));

    // R11: the interrupt implies the drop indication
    assert_irq_implies_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> line_drop);

endmodule

// File: tb/vcap_addr_gen_test.sv
module vcap_addr_gen_test;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wr;
    logic [2:0]    reg_addr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic          frame_start, field_start, field_odd, line_start;
    logic          fifo_overflow, fifo_reset;
    logic          line_valid, line_drop, ovf_irq;
    logic [AW-1:0] y_line_addr, u_line_addr, v_line_addr;

    int n_chk  = 0;
    int n_fail = 0;

    // reference state, built from the requirements
    logic [AW-1:0] mbase [6];
    logic [AW-1:0] mpy, mpuv;
    bit            m_planar, m_il, m_pf, m_pde, m_rec;
    logic [AW-1:0] mrun  [3];
    logic [AW-1:0] mline [3];
    int            mst;    // 0 run, 1 drop, 2 halt

    vcap_addr_gen #(.ADDR_W(AW)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .frame_start   (frame_start),
        .field_start   (field_start),
        .field_odd     (field_odd),
        .line_start    (line_start),
        .fifo_overflow (fifo_overflow),
        .fifo_reset    (fifo_reset),
        .line_valid    (line_valid),
        .y_line_addr   (y_line_addr),
        .u_line_addr   (u_line_addr),
        .v_line_addr   (v_line_addr),
        .line_drop     (line_drop),
        .ovf_irq       (ovf_irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a < 3'd6) mbase[a] = d[AW-1:0];
        else if (a == 3'd6) begin
            mpy  = d[15:0] & 16'hFFE0;
            mpuv = d[31:16] & 16'hFFE0;
        end else begin
            m_planar = d[0]; m_il = d[1]; m_pf = d[2]; m_pde = d[3]; m_rec = d[5];
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        @(negedge clk);
        chk(tag, "reg_rdata", reg_rdata, exp);
    endtask

    task automatic step(input bit fs, input bit fld, input bit odd, input bit ls,
                        input bit ov, input bit fr, input string tag);
        bit acc, rl, even;
        int bi;
        logic [AW-1:0] st;
        frame_start = fs; field_start = fld; field_odd = odd;
        line_start = ls; fifo_overflow = ov; fifo_reset = fr;
        acc  = ls && (mst != 2);
        rl   = (mst != 2) && (fs || (fld && m_il && m_pf));
        even = m_il && !odd;
        for (int p = 0; p < 3; p++) begin
            if (p != 0 && !m_planar) begin
                mrun[p] = '0; mline[p] = '0;
            end else begin
                bi = 2 * p + ((even && !(p != 0 && m_pde)) ? 1 : 0);
                st = rl ? mbase[bi] : mrun[p];
                if (acc) begin
                    mline[p] = st;
                    mrun[p]  = st + ((p == 0) ? mpy : mpuv);
                end else begin
                    mrun[p] = st;
                end
            end
        end
        case (mst)
            0: if (ov) mst = m_rec ? 1 : 2;
            1: if (ls && !ov) mst = 0;
            default: if (fr) mst = 0;
        endcase
        @(negedge clk);
        chk(tag, "line_valid", 32'(line_valid), 32'(acc));
        chk(tag, "y_line_addr", 32'(y_line_addr), 32'(mline[0]));
        chk(tag, "u_line_addr", 32'(u_line_addr), 32'(mline[1]));
        chk(tag, "v_line_addr", 32'(v_line_addr), 32'(mline[2]));
        chk(tag, "ovf_irq", 32'(ovf_irq), 32'(mst == 2));
        chk(tag, "line_drop", 32'(line_drop), 32'(mst != 0));
        frame_start = 0; field_start = 0; line_start = 0;
        fifo_overflow = 0; fifo_reset = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        frame_start = 0; field_start = 0; field_odd = 0; line_start = 0;
        fifo_overflow = 0; fifo_reset = 0;
        for (int i = 0; i < 6; i++) mbase[i] = '0;
        for (int p = 0; p < 3; p++) begin mrun[p] = '0; mline[p] = '0; end
        mpy = '0; mpuv = '0; mst = 0;
        m_planar = 0; m_il = 0; m_pf = 0; m_pde = 0; m_rec = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        chk("R1", "reset line_valid", 32'(line_valid), 32'd0);
        chk("R1", "reset y", 32'(y_line_addr), 32'd0);
        chk("R1", "reset irq", 32'(ovf_irq), 32'd0);
        for (int a = 0; a < 7; a++) rd(3'(a), 32'd0, "R1");
        rd(3'd7, 32'h0000_0020, "R1");

        // R1: pitch alignment and control masking
        wr(3'd6, 32'h1234_0567);
        rd(3'd6, 32'h1220_0560, "R1");
        wr(3'd7, 32'hFFFF_FFD0);
        rd(3'd7, 32'h0000_0000, "R1");
        wr(3'd7, 32'h0000_002F);
        rd(3'd7, 32'h0000_002F, "R1");
        wr(3'd2, 32'hABCD_1357);
        rd(3'd2, 32'h0000_1357, "R1");

        // sweep of all mode-bit combinations
        for (int cfg = 0; cfg < 16; cfg++) begin
            wr(3'd7, {26'b0, 1'b1, 1'b0, 4'(cfg)});
            for (int i = 0; i < 6; i++) wr(3'(i), 32'h1000 * (i + 1) + 32'h40 * cfg);
            wr(3'd6, {16'(32'h20 * (cfg + 1)), 16'(32'h40 + 32'h20 * cfg)});
            step(1, 0, 1, 1, 0, 0, "R9");
            repeat (2) step(0, 0, 0, 1, 0, 0, "R2");
            step(0, 1, 0, 0, 0, 0, "R6");
            repeat (2) step(0, 0, 0, 1, 0, 0, "R8");
            step(0, 1, 1, 1, 0, 0, "R7");
            step(1, 0, 0, 0, 0, 0, "R5");
            repeat (2) step(0, 0, 0, 1, 0, 0, "R3");
            step(0, 0, 1, 1, 0, 0, "R4");
        end

        // R12: wrap at 2^ADDR_W
        wr(3'd7, 32'h0000_0021);
        wr(3'd0, 32'h0000_FFE0);
        wr(3'd2, 32'h0000_FFC0);
        wr(3'd4, 32'h0000_FFA0);
        wr(3'd6, 32'h0060_0040);
        step(1, 0, 1, 0, 0, 0, "R12");
        repeat (3) step(0, 0, 0, 1, 0, 0, "R12");

        // R10: overflow without recovery
        wr(3'd7, 32'h0000_0000);
        step(1, 0, 1, 1, 0, 0, "R10");
        step(0, 0, 0, 0, 1, 0, "R10");
        repeat (2) step(0, 0, 0, 1, 0, 0, "R10");
        step(1, 0, 1, 1, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 1, "R10");
        repeat (2) step(0, 0, 0, 1, 0, 0, "R10");

        // R11: overflow with recovery
        wr(3'd7, 32'h0000_0020);
        step(0, 0, 0, 0, 1, 0, "R11");
        step(0, 0, 0, 0, 0, 0, "R11");
        step(0, 0, 0, 1, 0, 0, "R11");
        step(0, 0, 0, 1, 0, 0, "R11");

        finish_run();
    end

endmodule